// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block sits between an on-chip request port and an external 128K x 8 asynchronous static RAM. A client presents one read or one write at a time with a valid/ready handshake. The controller registers the address and write data, then steps the memory's strobes through a fixed sequence of phases. The strobes are a low-true chip select, a high-true chip select, a low-true write strobe and a low-true output enable. Each phase lasts a whole number of system clock cycles. The cycle counts come from the memory's timing limits divided by the clock period, rounded up.

Writes are framed so that the address is stable and the chip is selected for one cycle before the write strobe falls, and for one cycle after it rises. The controller drives the data bus only while the write strobe is low. Reads hold the output enable low for the access time and sample the bus on the last cycle of that phase. The read byte is then returned with a one-cycle valid pulse. After every read the chip is deselected for a turnaround gap, so that the memory's output has gone quiet before the controller can drive the bus again.

Top module: `asram_ctrl`

## Requirements
- R1: While reset is low, and in the first idle cycle after it, both chip selects are inactive, the write strobe and output enable are high, the data driver is off, and req_ready is high once the internal reset has been released.
- R2: req_ready is high only when no access is in progress. A request is taken on a clock edge where req_valid and req_ready are both high, with req_we = 1 meaning write and req_we = 0 meaning read.
- R3: A write selects the chip with the write strobe high for one cycle. It then holds the write strobe low for WP_CYC cycles and keeps the chip selected with the write strobe high for one more cycle, and then returns to idle.
- R4: sram_addr carries the accepted address for every cycle in which the chip is selected, and it does not change in a cycle where the write strobe falls or rises.
- R5: sram_dq_oe is high exactly in the cycles where the write strobe is low, and it is never high while the output enable is low.
- R6: A read selects the chip with the output enable low and the write strobe high for RD_CYC consecutive cycles.
- R7: The byte on sram_dq_in during the last output-enable-low cycle of a read appears on rd_data, with rd_valid high for exactly one cycle, in the cycle right after that phase ends.
- R8: After a read, the chip stays deselected and req_ready stays low for TA_CYC cycles. The data driver therefore rises no earlier than TA_CYC + 2 cycles after the output enable rises.
- R9: The two chip selects always agree: sram_ce_n is low exactly when sram_ce is high. While the chip is deselected, the write strobe and output enable are high and the driver is off.
- R10: During every cycle in which the write strobe is low, sram_dq_out equals the write data accepted with that request.
- R11: A request held while the controller is busy is not taken. It leaves the strobes, the address and the memory contents unchanged.
- R12: RD_CYC = ceil(access time / period) and WP_CYC = max of the rounded-up write pulse, address-to-write-end less one cycle, data setup, and write cycle less two cycles. TA_CYC = max(1, ceil(output-disable time / period)). The defaults at a 10 ns clock give 7, 5 and 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Word address |
| req_wdata | input | 8 | Write data |
| rd_valid | output | 1 | One-cycle pulse marking rd_data valid |
| rd_data | output | 8 | Byte returned by a read |
| sram_addr | output | 17 | Address to the memory |
| sram_dq_out | output | 8 | Data driven toward the memory |
| sram_dq_oe | output | 1 | Enable of the bus driver for sram_dq_out |
| sram_dq_in | input | 8 | Data received from the memory's bus |
| sram_ce_n | output | 1 | Chip select, active low |
| sram_ce | output | 1 | Chip select, active high |
| sram_we_n | output | 1 | Write strobe, active low |
| sram_oe_n | output | 1 | Output enable, active low |

## Verification
The bench's memory model puts a poison byte on the bus until the read has spent RD_CYC cycles with the output enable low. A controller that samples one cycle early therefore returns the poison value instead of the stored byte. A read followed at once by a write measures the gap between the output enable rising and the driver turning on. A design that skips the turnaround would show the driver fighting the memory within fewer than TA_CYC + 2 cycles. A request held high through a busy write, aimed at a different address, is read back afterwards: a controller that took it early would have stored the decoy byte. Writes and reads to the lowest and highest addresses, with all-zero, all-one and alternating data, expose address or data bits that are swapped, stuck, or changed while the write strobe is low.

// File: rtl/asram_pkg.sv
package asram_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_WSETUP = 3'd1,
    ST_WPULSE = 3'd2,
    ST_WREC   = 3'd3,
    ST_RACC   = 3'd4,
    ST_RTURN  = 3'd5
  } state_e;

  function automatic int cdiv(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/asram_phase_timer.sv
module asram_phase_timer #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             done
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    if (load) cnt_d = load_val;
    else      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign done = (cnt_q == '0);

endmodule

// File: rtl/asram_seq.sv
module asram_seq
  import asram_pkg::*;
#(
  parameter int RD_CYC = 7,
  parameter int WP_CYC = 5,
  parameter int TA_CYC = 3,
  parameter int CNT_W  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_we,
  input  logic             tmr_done,
  output logic             req_ready,
  output logic             accept,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_val,
  output logic             capture,
  output logic             ce_n,
  output logic             ce,
  output logic             we_n,
  output logic             oe_n,
  output logic             dq_oe
);

  localparam logic [CNT_W-1:0] RD_LAST = CNT_W'(RD_CYC - 1);
  localparam logic [CNT_W-1:0] WP_LAST = CNT_W'(WP_CYC - 1);
  localparam logic [CNT_W-1:0] TA_LAST = CNT_W'(TA_CYC - 1);

  state_e state_q, state_d;
  logic   ce_n_d, ce_d, we_n_d, oe_n_d, dq_oe_d;

  always_comb begin
    state_d  = state_q;
    accept   = 1'b0;
    tmr_load = 1'b0;
    tmr_val  = '0;
    capture  = 1'b0;
    unique case (state_q)
      ST_IDLE: if (req_valid) begin
        accept = 1'b1;
        if (req_we) begin
          state_d = ST_WSETUP;
        end else begin
          state_d  = ST_RACC;
          tmr_load = 1'b1;
          tmr_val  = RD_LAST;
        end
      end
      ST_WSETUP: begin
        state_d  = ST_WPULSE;
        tmr_load = 1'b1;
        tmr_val  = WP_LAST;
      end
      ST_WPULSE: if (tmr_done) state_d = ST_WREC;
      ST_WREC:   state_d = ST_IDLE;
      ST_RACC: if (tmr_done) begin
        capture  = 1'b1;
        state_d  = ST_RTURN;
        tmr_load = 1'b1;
        tmr_val  = TA_LAST;
      end
      ST_RTURN: if (tmr_done) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    ce_n_d  = (state_d == ST_IDLE) || (state_d == ST_RTURN);
    ce_d    = !ce_n_d;
    we_n_d  = (state_d != ST_WPULSE);
    oe_n_d  = (state_d != ST_RACC);
    dq_oe_d = (state_d == ST_WPULSE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ce_n    <= 1'b1;
      ce      <= 1'b0;
      we_n    <= 1'b1;
      oe_n    <= 1'b1;
      dq_oe   <= 1'b0;
    end else begin
      state_q <= state_d;
      ce_n    <= ce_n_d;
      ce      <= ce_d;
      we_n    <= we_n_d;
      oe_n    <= oe_n_d;
      dq_oe   <= dq_oe_d;
    end
  end

  assign req_ready = (state_q == ST_IDLE);

  // R3: the write strobe only falls after a cycle with the chip already selected
  p_we_setup_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(we_n) |-> $past(!ce_n && ce && we_n));

  // R6: output enable low only with the chip selected and the write strobe high
  p_read_strobes_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n |-> (!ce_n && ce && we_n));

  // R9: deselected chip keeps both strobes inactive and the driver off
  p_standby_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |-> (we_n && oe_n && !dq_oe));

endmodule

// File: rtl/asram_dpath.sv
module asram_dpath #(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              capture,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] dq_in,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] dq_out,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr   <= '0;
      dq_out <= '0;
    end else if (accept) begin
      addr   <= req_addr;
      dq_out <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rd_data <= '0;
    else if (capture) rd_data <= dq_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_valid <= 1'b0;
    else        rd_valid <= capture;
  end

  // R7: a returned byte is presented for one cycle only
  p_valid_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
  import asram_pkg::*;
#(
  parameter int ADDR_W        = 17,
  parameter int DATA_W        = 8,
  parameter int CLK_PERIOD_PS = 10000,
  parameter int T_AA_PS       = 70000,
  parameter int T_WP_PS       = 50000,
  parameter int T_AW_PS       = 60000,
  parameter int T_DW_PS       = 30000,
  parameter int T_WC_PS       = 70000,
  parameter int T_OHZ_PS      = 25000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] sram_addr,
  output logic [DATA_W-1:0] sram_dq_out,
  output logic              sram_dq_oe,
  input  logic [DATA_W-1:0] sram_dq_in,
  output logic              sram_ce_n,
  output logic              sram_ce,
  output logic              sram_we_n,
  output logic              sram_oe_n
);

  localparam int RD_CYC = max2(1, cdiv(T_AA_PS, CLK_PERIOD_PS));
  localparam int WP_CYC = max2(max2(1, cdiv(T_WP_PS, CLK_PERIOD_PS)),
                          max2(max2(cdiv(T_AW_PS, CLK_PERIOD_PS) - 1,
                                    cdiv(T_DW_PS, CLK_PERIOD_PS)),
                               cdiv(T_WC_PS, CLK_PERIOD_PS) - 2));
  localparam int TA_CYC = max2(1, cdiv(T_OHZ_PS, CLK_PERIOD_PS));
  localparam int CNT_W  = $clog2(max2(RD_CYC, max2(WP_CYC, TA_CYC)) + 1);

  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  logic             accept, capture, tmr_load, tmr_done;
  logic [CNT_W-1:0] tmr_val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  asram_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .done     (tmr_done)
  );

  asram_seq #(
    .RD_CYC (RD_CYC),
    .WP_CYC (WP_CYC),
    .TA_CYC (TA_CYC),
    .CNT_W  (CNT_W)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .req_valid (req_valid),
    .req_we    (req_we),
    .tmr_done  (tmr_done),
    .req_ready (req_ready),
    .accept    (accept),
    .tmr_load  (tmr_load),
    .tmr_val   (tmr_val),
    .capture   (capture),
    .ce_n      (sram_ce_n),
    .ce        (sram_ce),
    .we_n      (sram_we_n),
    .oe_n      (sram_oe_n),
    .dq_oe     (sram_dq_oe)
  );

  asram_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dpath (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .accept    (accept),
    .capture   (capture),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .dq_in     (sram_dq_in),
    .addr      (sram_addr),
    .dq_out    (sram_dq_out),
    .rd_data   (rd_data),
    .rd_valid  (rd_valid)
  );

  // R2: the port reports ready only while the memory is idle and deselected
  p_ready_idle_r2: assert property (@(posedge clk) disable iff (!rst_int_n)
    req_ready |-> (sram_ce_n && !sram_ce));

  // R4: address held across the falling and rising write strobe
  p_addr_fall_r4: assert property (@(posedge clk) disable iff (!rst_int_n)
    $fell(sram_we_n) |-> $stable(sram_addr));
  p_addr_rise_r4: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(sram_we_n) |-> $stable(sram_addr));

  // R5: driver on only under a low write strobe, never against output enable
  p_drv_we_r5: assert property (@(posedge clk) disable iff (!rst_int_n)
    sram_dq_oe |-> !sram_we_n);
  p_drv_oe_r5: assert property (@(posedge clk) disable iff (!rst_int_n)
    sram_dq_oe |-> sram_oe_n);

  // R7: read byte returned just after the output enable phase ends
  p_valid_after_oe_r7: assert property (@(posedge clk) disable iff (!rst_int_n)
    rd_valid |-> (sram_oe_n && $past(!sram_oe_n)));

  // R8: the end of a read is followed by a gap, not an immediate ready
  p_turn_r8: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(sram_oe_n) |-> (!req_ready && sram_ce_n));

endmodule

// File: tb/asram_ctrl_tb.sv
module asram_ctrl_tb;

  localparam int RD = 7;
  localparam int WP = 5;
  localparam int TA = 3;

  typedef struct {
    bit          ce_n;
    bit          we_n;
    bit          oe_n;
    bit          dq_oe;
    bit          ready;
    bit          rv;
    logic [16:0] addr;
    logic [7:0]  dout;
    logic [7:0]  rdat;
  } rec_t;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_we;
  logic [16:0] req_addr;
  logic [7:0]  req_wdata;
  logic        req_ready, rd_valid;
  logic [7:0]  rd_data;
  logic [16:0] sram_addr;
  logic [7:0]  sram_dq_out, sram_dq_in;
  logic        sram_dq_oe, sram_ce_n, sram_ce, sram_we_n, sram_oe_n;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  int oe_run = 0, we_run = 0, oe_k = 0, t_oe_up = -1;
  bit prev_dq_oe = 1'b0;
  rec_t exp_q[$];
  logic [7:0] mem  [logic [16:0]];
  logic [7:0] gold [logic [16:0]];

  always #5 clk = ~clk;

  asram_ctrl u_dut (
    .clk (clk), .rst_n (rst_n),
    .req_valid (req_valid), .req_ready (req_ready), .req_we (req_we),
    .req_addr (req_addr), .req_wdata (req_wdata),
    .rd_valid (rd_valid), .rd_data (rd_data),
    .sram_addr (sram_addr), .sram_dq_out (sram_dq_out), .sram_dq_oe (sram_dq_oe),
    .sram_dq_in (sram_dq_in), .sram_ce_n (sram_ce_n), .sram_ce (sram_ce),
    .sram_we_n (sram_we_n), .sram_oe_n (sram_oe_n)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s cycle %0d actual=%0h expected=%0h", tag, cyc, act, exp);
    end
  endtask

  function automatic rec_t idle_rec();
    rec_t r;
    r.ce_n = 1; r.we_n = 1; r.oe_n = 1; r.dq_oe = 0; r.ready = 1; r.rv = 0;
    r.addr = '0; r.dout = '0; r.rdat = '0;
    return r;
  endfunction

  function automatic logic [7:0] peek(input logic [16:0] a, input bit golden);
    if (golden) return gold.exists(a) ? gold[a] : 8'h00;
    return mem.exists(a) ? mem[a] : 8'h00;
  endfunction

  task automatic push_op(input bit we, input logic [16:0] a, input logic [7:0] d);
    rec_t r;
    r = idle_rec();
    r.ready = 0; r.ce_n = 0; r.addr = a;
    if (we) begin
      exp_q.push_back(r);
      r.we_n = 0; r.dq_oe = 1; r.dout = d;
      for (int i = 0; i < WP; i++) exp_q.push_back(r);
      r.we_n = 1; r.dq_oe = 0;
      exp_q.push_back(r);
      gold[a] = d;
    end else begin
      r.oe_n = 0;
      for (int i = 0; i < RD; i++) exp_q.push_back(r);
      r.oe_n = 1; r.ce_n = 1;
      for (int i = 0; i < TA; i++) begin
        r.rv = (i == 0);
        r.rdat = peek(a, 1'b1);
        exp_q.push_back(r);
      end
    end
  endtask

  task automatic cycle(input bit v, input bit we, input logic [16:0] a, input logic [7:0] d);
    rec_t cur;
    @(negedge clk);
    cyc++;
    if (exp_q.size() > 0) cur = exp_q.pop_front();
    else cur = idle_rec();
    chk(sram_ce_n == cur.ce_n, "R9 ce_n", sram_ce_n, cur.ce_n);
    chk(sram_ce == !sram_ce_n, "R9 ce pair", sram_ce, !sram_ce_n);
    chk(sram_we_n == cur.we_n, "R3 we_n", sram_we_n, cur.we_n);
    chk(sram_oe_n == cur.oe_n, "R6 oe_n", sram_oe_n, cur.oe_n);
    chk(sram_dq_oe == cur.dq_oe, "R5 dq_oe", sram_dq_oe, cur.dq_oe);
    chk(req_ready == cur.ready, "R2 ready", req_ready, cur.ready);
    chk(rd_valid == cur.rv, "R7 rd_valid", rd_valid, cur.rv);
    if (!cur.ce_n) chk(sram_addr == cur.addr, "R4 addr", sram_addr, cur.addr);
    if (cur.dq_oe) chk(sram_dq_out == cur.dout, "R10 dq_out", sram_dq_out, cur.dout);
    if (cur.rv) chk(rd_data == cur.rdat, "R7 rd_data", rd_data, cur.rdat);
    // R12: phase lengths measured at the pins
    if (!sram_oe_n) oe_run++;
    else begin
      if (oe_run > 0) begin
        chk(oe_run == RD, "R12 read phase", oe_run, RD);
        t_oe_up = cyc;
      end
      oe_run = 0;
    end
    if (!sram_we_n) we_run++;
    else begin
      if (we_run > 0) chk(we_run == WP, "R12 write pulse", we_run, WP);
      we_run = 0;
    end
    // R8: gap from read end to driver turn-on
    if (sram_dq_oe && !prev_dq_oe && t_oe_up >= 0)
      chk((cyc - t_oe_up) >= TA + 2, "R8 turnaround", cyc - t_oe_up, TA + 2);
    prev_dq_oe = sram_dq_oe;
    // memory model: data valid only after the full access time
    if (!sram_ce_n && sram_ce && !sram_oe_n && sram_we_n) begin
      oe_k++;
      sram_dq_in = (oe_k >= RD) ? peek(sram_addr, 1'b0) : 8'hEE;
    end else begin
      oe_k = 0;
      sram_dq_in = 8'hEE;
    end
    if (!sram_ce_n && sram_ce && !sram_we_n && sram_dq_oe) mem[sram_addr] = sram_dq_out;
    req_valid = v; req_we = we; req_addr = a; req_wdata = d;
    if (v && cur.ready) push_op(we, a, d);
  endtask

  task automatic op(input bit we, input logic [16:0] a, input logic [7:0] d);
    cycle(1'b1, we, a, d);
    while (exp_q.size() > 0) cycle(1'b0, 1'b0, '0, '0);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog all requirements actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 0; req_we = 0; req_addr = '0; req_wdata = '0;
    sram_dq_in = 8'hEE;
    repeat (3) @(negedge clk);
    // R1: outputs during reset
    chk(sram_ce_n && !sram_ce && sram_we_n && sram_oe_n && !sram_dq_oe, "R1 in reset",
        {sram_ce_n, sram_ce, sram_we_n, sram_oe_n, sram_dq_oe}, 5'b10110);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(req_ready && sram_ce_n && !sram_dq_oe && !rd_valid, "R1 after reset",
        {req_ready, sram_ce_n, sram_dq_oe, rd_valid}, 4'b1100);
    cycle(0, 0, '0, '0);
    // writes with boundary addresses and patterns (R3, R4, R10)
    op(1, 17'h00000, 8'hAA);
    op(1, 17'h1FFFF, 8'h55);
    op(1, 17'h15555, 8'hFF);
    op(1, 17'h0AAAA, 8'h00);
    // reads back (R6, R7)
    op(0, 17'h00000, 8'h00);
    op(0, 17'h1FFFF, 8'h00);
    op(0, 17'h15555, 8'h00);
    op(0, 17'h0AAAA, 8'h00);
    op(0, 17'h00123, 8'h00);
    // read with a write held waiting right behind it (R8)
    cycle(1, 0, 17'h1FFFF, 8'h00);
    while (exp_q.size() > 0) cycle(1, 1, 17'h00777, 8'h3C);
    cycle(1, 1, 17'h00777, 8'h3C);
    while (exp_q.size() > 0) cycle(0, 0, '0, '0);
    op(0, 17'h00777, 8'h00);
    // R11: a decoy request held during a busy write is ignored
    cycle(1, 1, 17'h00042, 8'h81);
    repeat (WP) cycle(1, 1, 17'h00099, 8'h7E);
    while (exp_q.size() > 0) cycle(0, 0, '0, '0);
    chk(!mem.exists(17'h00099), "R11 decoy not written", peek(17'h00099, 1'b0), 8'h00);
    op(0, 17'h00099, 8'h00);
    op(0, 17'h00042, 8'h00);
    // back-to-back writes then read of overwritten location
    op(1, 17'h00000, 8'h5A);
    op(1, 17'h00000, 8'hC3);
    op(0, 17'h00000, 8'h00);
    repeat (4) cycle(0, 0, '0, '0);
    summary();
    $finish;
  end

endmodule